// File: doc/BRIEF.md
# Power Mode Controller

This block keeps track of the power mode a small microcontroller is in and derives from it the oscillator enables and the CPU clock gate. Software selects a running mode by writing clock-control register bits. The block watches those bit values and switches only when they form one of the three valid running-mode combinations. Any other combination leaves the mode alone.

Two sleep modes sit beside the running modes. Wait is entered through a one-cycle strobe raised when the core executes its wait instruction; the CPU clock is gated but the oscillators keep running. Stop is entered through a stop-request register bit; every oscillator and the CPU clock are switched off. Both sleep modes are left only on an interrupt request, and the block then resumes the running mode that was active before it went to sleep. When stop is left, the block raises a one-cycle pulse that clears the stop-request bit in the register.

Clock division (high versus medium speed) and the oscillator circuits are outside this block. Both external-clock speeds share one mode code.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset is released the mode is low-speed on-chip oscillator. The mode codes are 0 = external clock, 1 = high-speed on-chip oscillator, 2 = low-speed on-chip oscillator, 3 = wait and 4 = stop.
- R2: In a running mode with no sleep request, the mode becomes external clock (code 0) one clock after the inputs show osc_sel=0, main_stop=0 and src_sel=1.
- R3: In a running mode with no sleep request, the mode becomes high-speed on-chip oscillator (code 1) one clock after the inputs show osc_sel=1, hso_en=1 and hso_sel=1.
- R4: In a running mode with no sleep request, the mode becomes low-speed on-chip oscillator (code 2) one clock after the inputs show osc_sel=1, hso_sel=0 and lso_dis=0.
- R5: In a running mode, a bit combination that matches none of R2 to R4 leaves the mode unchanged.
- R6: A wait_stb pulse in a running mode moves to wait (code 3). While in wait, cpu_clk_en is 0 and register changes have no effect on the mode.
- R7: A stop_req of 1 in a running mode moves to stop (code 4) and takes priority over a wait_stb in the same cycle. While in stop, all oscillator enables and cpu_clk_en are 0.
- R8: From wait or stop, an irq moves the mode, one clock later, back to the running mode that was active before entry. Without irq the sleep mode is held.
- R9: stop_clr is 1 for exactly the one clock that follows the exit from stop. While stop_clr is 1, stop_req is ignored.
- R10: In a running mode, cpu_clk_en is 1. The oscillator feeding the current running mode, or the mode saved during wait, has its enable forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_sel | input | 1 | 1 selects an on-chip oscillator as source |
| main_stop | input | 1 | 1 turns the external main clock off |
| src_sel | input | 1 | 1 routes the external main clock to the system |
| hso_en | input | 1 | High-speed on-chip oscillator enable |
| hso_sel | input | 1 | 1 selects high-speed over low-speed on-chip oscillator |
| lso_dis | input | 1 | 1 turns the low-speed on-chip oscillator off |
| stop_req | input | 1 | Stop-request register bit |
| wait_stb | input | 1 | One-cycle wait-instruction strobe |
| irq | input | 1 | Interrupt request |
| mode | output | 3 | Current mode code (see R1) |
| ext_osc_en | output | 1 | External oscillator enable |
| hso_osc_en | output | 1 | High-speed on-chip oscillator enable |
| lso_osc_en | output | 1 | Low-speed on-chip oscillator enable |
| cpu_clk_en | output | 1 | CPU clock gate |
| stop_clr | output | 1 | Pulse that clears the stop-request bit |

## Verification
The hardest case to reach is the return from sleep after software has rewritten the clock bits during sleep. The FSM must first restore the saved mode and only then follow the new bits. The bench enters wait from the high-speed on-chip mode and, while asleep, changes the inputs to the external-clock combination. It then raises irq and samples the mode both in the cycle that follows the interrupt and in the next cycle. The stop exit is driven the same way, with stop_req still high. In that case the bench acts as the register and clears the bit only once it sees stop_clr.

// File: rtl/pwr_mode_pkg.sv
// Package: shared mode encoding for the power mode controller.
// Assumes codes fit in MODE_W bits; running modes are codes below MD_WAIT.
package pwr_mode_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_EXT  = 3'd0,
        MD_HSO  = 3'd1,
        MD_LSO  = 3'd2,
        MD_WAIT = 3'd3,
        MD_STOP = 3'd4
    } mode_e;

    function automatic logic is_running(input mode_e m);
        return (m == MD_EXT) || (m == MD_HSO) || (m == MD_LSO);
    endfunction
endpackage

// File: rtl/pwr_mode_decode.sv
// Module: maps clock-control bit values to a running-mode target.
// Assumes the three valid combinations are mutually exclusive (hso_sel and
// osc_sel separate them); tgt_vld is low for any other combination.
module pwr_mode_decode
    import pwr_mode_pkg::*;
(
    input  logic  osc_sel,
    input  logic  main_stop,
    input  logic  src_sel,
    input  logic  hso_en,
    input  logic  hso_sel,
    input  logic  lso_dis,
    output mode_e tgt,
    output logic  tgt_vld
);
    logic sel_ext, sel_hso, sel_lso;

    // Purpose: recognise each valid running-mode combination.
    always_comb begin
        sel_ext = !osc_sel && !main_stop && src_sel;
        sel_hso = osc_sel && hso_en && hso_sel;
        sel_lso = osc_sel && !hso_sel && !lso_dis;
    end

    // Purpose: pick the matching target and flag whether any matched.
    always_comb begin
        tgt     = MD_LSO;
        tgt_vld = 1'b1;
        if (sel_ext)      tgt = MD_EXT;
        else if (sel_hso) tgt = MD_HSO;
        else if (sel_lso) tgt = MD_LSO;
        else              tgt_vld = 1'b0;
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
// Module: mode state machine with the saved running mode for sleep exit.
// Assumes wait_stb is a one-cycle pulse and that stop_req is held by the
// register until stop_clr clears it.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e tgt,
    input  logic  tgt_vld,
    input  logic  stop_req,
    input  logic  wait_stb,
    input  logic  irq,
    output mode_e state,
    output mode_e saved,
    output logic  stop_clr
);
    mode_e nxt;
    logic  save_now;

    // Purpose: next-state choice; stop wins over wait, sleep exits only on irq.
    always_comb begin
        nxt      = state;
        save_now = 1'b0;
        if (is_running(state)) begin
            if (stop_req && !stop_clr) begin
                nxt      = MD_STOP;
                save_now = 1'b1;
            end else if (wait_stb) begin
                nxt      = MD_WAIT;
                save_now = 1'b1;
            end else if (tgt_vld) begin
                nxt = tgt;
            end
        end else if (irq) begin
            nxt = saved;
        end
    end

    // Purpose: register the mode, the saved running mode and the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= MD_LSO;
            saved    <= MD_LSO;
            stop_clr <= 1'b0;
        end else begin
            state    <= nxt;
            if (save_now) saved <= state;
            stop_clr <= (state == MD_STOP) && irq;
        end
    end
endmodule

// File: rtl/pwr_clk_gate.sv
// Module: derives oscillator enables and the CPU clock gate from the mode.
// Assumes saved holds the running mode whenever state is a sleep mode.
module pwr_clk_gate
    import pwr_mode_pkg::*;
(
    input  mode_e state,
    input  mode_e saved,
    input  logic  main_stop,
    input  logic  hso_en,
    input  logic  lso_dis,
    output logic  ext_osc_en,
    output logic  hso_osc_en,
    output logic  lso_osc_en,
    output logic  cpu_clk_en
);
    mode_e src;
    logic  halt;

    // Purpose: find the mode whose source must stay alive.
    always_comb begin
        src  = is_running(state) ? state : saved;
        halt = (state == MD_STOP);
    end

    // Purpose: enables follow the register bits, the active source is forced on.
    always_comb begin
        ext_osc_en = !halt && (!main_stop || src == MD_EXT);
        hso_osc_en = !halt && (hso_en || src == MD_HSO);
        lso_osc_en = !halt && (!lso_dis || src == MD_LSO);
        cpu_clk_en = is_running(state);
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: top of the power mode controller; ties decode, FSM and gating.
// Assumes all inputs are synchronous to clk.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_sel,
    input  logic              main_stop,
    input  logic              src_sel,
    input  logic              hso_en,
    input  logic              hso_sel,
    input  logic              lso_dis,
    input  logic              stop_req,
    input  logic              wait_stb,
    input  logic              irq,
    output logic [MODE_W-1:0] mode,
    output logic              ext_osc_en,
    output logic              hso_osc_en,
    output logic              lso_osc_en,
    output logic              cpu_clk_en,
    output logic              stop_clr
);
    mode_e tgt, state, saved;
    logic  tgt_vld;

    pwr_mode_decode u_dec (
        .osc_sel(osc_sel), .main_stop(main_stop), .src_sel(src_sel),
        .hso_en(hso_en), .hso_sel(hso_sel), .lso_dis(lso_dis),
        .tgt(tgt), .tgt_vld(tgt_vld)
    );

    pwr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .tgt_vld(tgt_vld),
        .stop_req(stop_req), .wait_stb(wait_stb), .irq(irq),
        .state(state), .saved(saved), .stop_clr(stop_clr)
    );

    pwr_clk_gate u_gate (
        .state(state), .saved(saved), .main_stop(main_stop),
        .hso_en(hso_en), .lso_dis(lso_dis),
        .ext_osc_en(ext_osc_en), .hso_osc_en(hso_osc_en),
        .lso_osc_en(lso_osc_en), .cpu_clk_en(cpu_clk_en)
    );

    // Purpose: expose the mode code.
    always_comb mode = state;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Module: property checker for pwr_mode_ctrl, bound to every instance.
// Keeps its own record of the last running mode to judge sleep exits.
module pwr_mode_ctrl_chk
    import pwr_mode_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              osc_sel,
    input logic              main_stop,
    input logic              src_sel,
    input logic              stop_req,
    input logic              wait_stb,
    input logic              irq,
    input logic [MODE_W-1:0] mode,
    input logic              ext_osc_en,
    input logic              hso_osc_en,
    input logic              lso_osc_en,
    input logic              cpu_clk_en,
    input logic              stop_clr
);
    logic [MODE_W-1:0] last_run;
    logic              run, sleep;

    // Purpose: classify the observed mode.
    always_comb begin
        run   = (mode < MODE_W'(MD_WAIT));
        sleep = (mode == MODE_W'(MD_WAIT)) || (mode == MODE_W'(MD_STOP));
    end

    // Purpose: remember the most recent running mode.
    always_ff @(posedge clk) begin
        if (!rst_n)   last_run <= MODE_W'(MD_LSO);
        else if (run) last_run <= mode;
    end

    assert_ext_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !stop_req && !wait_stb && !osc_sel && !main_stop && src_sel)
        |=> (mode == MODE_W'(MD_EXT)));

    assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !irq) |=> $stable(mode));

    assert_sleep_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && irq) |=> (mode == last_run));

    assert_stop_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_W'(MD_STOP)) |-> (!ext_osc_en && !hso_osc_en && !lso_osc_en && !cpu_clk_en));

    assert_stop_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && stop_req && !stop_clr) |=> (mode == MODE_W'(MD_STOP)));

    assert_clr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_W'(MD_STOP)) && irq) |=> stop_clr);

    assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_clr |=> !stop_clr);

    assert_cpu_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cpu_clk_en);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .osc_sel(osc_sel), .main_stop(main_stop),
    .src_sel(src_sel), .stop_req(stop_req), .wait_stb(wait_stb), .irq(irq),
    .mode(mode), .ext_osc_en(ext_osc_en), .hso_osc_en(hso_osc_en),
    .lso_osc_en(lso_osc_en), .cpu_clk_en(cpu_clk_en), .stop_clr(stop_clr)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_sel = 1'b1, main_stop = 1'b1, src_sel = 1'b0;
    logic hso_en = 1'b0, hso_sel = 1'b0, lso_dis = 1'b0;
    logic stop_req = 1'b0, wait_stb = 1'b0, irq = 1'b0;
    logic [2:0] mode;
    logic ext_osc_en, hso_osc_en, lso_osc_en, cpu_clk_en, stop_clr;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .osc_sel(osc_sel), .main_stop(main_stop),
        .src_sel(src_sel), .hso_en(hso_en), .hso_sel(hso_sel), .lso_dis(lso_dis),
        .stop_req(stop_req), .wait_stb(wait_stb), .irq(irq), .mode(mode),
        .ext_osc_en(ext_osc_en), .hso_osc_en(hso_osc_en), .lso_osc_en(lso_osc_en),
        .cpu_clk_en(cpu_clk_en), .stop_clr(stop_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: inputs already set at negedge, sample after next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
        chk("R1 mode", mode, 2);
        chk("R10 cpu", cpu_clk_en, 1);
        chk("R10 lso", lso_osc_en, 1);
    endtask

    task automatic t_ext();
        osc_sel = 1'b0; main_stop = 1'b0; src_sel = 1'b1; step();
        chk("R2 mode", mode, 0);
        chk("R10 ext", ext_osc_en, 1);
    endtask

    task automatic t_hso();
        hso_en = 1'b1; hso_sel = 1'b1; osc_sel = 1'b1; step();
        chk("R3 mode", mode, 1);
        chk("R10 hso", hso_osc_en, 1);
    endtask

    task automatic t_invalid();
        hso_en = 1'b0; step();            // osc_sel=1, hso_sel=1, hso_en=0: no match
        chk("R5 hold", mode, 1);
        chk("R10 forced hso", hso_osc_en, 1);
        hso_sel = 1'b0; lso_dis = 1'b1; step(); // osc_sel=1, hso_sel=0, lso_dis=1
        chk("R5 hold2", mode, 1);
        hso_en = 1'b1; hso_sel = 1'b1; lso_dis = 1'b0; step();
    endtask

    task automatic t_wait();
        wait_stb = 1'b1; step(); wait_stb = 1'b0;
        chk("R6 mode", mode, 3);
        chk("R6 cpu", cpu_clk_en, 0);
        osc_sel = 1'b0; main_stop = 1'b0; src_sel = 1'b1; step(); step();
        chk("R6 ignore regs", mode, 3);
        chk("R8 hold", mode, 3);
        irq = 1'b1; step(); irq = 1'b0;
        chk("R8 return", mode, 1);
        step();
        chk("R2 after return", mode, 0);
        osc_sel = 1'b1; step();
        chk("R3 back", mode, 1);
    endtask

    task automatic t_stop();
        stop_req = 1'b1; wait_stb = 1'b1; step(); wait_stb = 1'b0;
        chk("R7 priority", mode, 4);
        chk("R7 ext", ext_osc_en, 0);
        chk("R7 hso", hso_osc_en, 0);
        chk("R7 lso", lso_osc_en, 0);
        chk("R7 cpu", cpu_clk_en, 0);
        step();
        chk("R8 stop hold", mode, 4);
        chk("R9 no clr", stop_clr, 0);
        irq = 1'b1; step(); irq = 1'b0;
        chk("R8 stop return", mode, 1);
        chk("R9 clr", stop_clr, 1);
        if (stop_clr) stop_req = 1'b0;
        step();
        chk("R9 no reentry", mode, 1);
        chk("R9 clr end", stop_clr, 0);
    endtask

    task automatic t_lso();
        hso_sel = 1'b0; lso_dis = 1'b0; step();
        chk("R4 mode", mode, 2);
        chk("R10 lso on", lso_osc_en, 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_ext();
        t_hso();
        t_invalid();
        t_wait();
        t_stop();
        t_lso();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                chk("watchdog", 0, 1);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule